// File: doc/BRIEF.md
# Processor-Side Interrupt Interface with Nested Preemption

This block stands between the interrupt distributor and one processor core. The distributor delivers two things: a vector of forwarded pending lines and an 8-bit priority for each line. The block picks the most urgent line. It raises the request wire to the core when that line is allowed to interrupt the work already in progress. It also serves a small word-addressed register bus, which software uses to claim, inspect and retire interrupts.

Software claims an interrupt by reading the claim register. The read returns the winning ID, marks that line as in service, and pushes the line's group priority onto an in-service stack. Software retires the interrupt by writing its ID to the retire register, which pops the stack and restores the previous running priority. A split point divides every priority into a group part and a subpriority part. Only the group part decides whether a new line may interrupt a running handler. The full value decides the order among lines that are waiting. ID 1023 means "nothing to hand out".

Register map (word address on `regAddr`): 0 control (bit 0 = interface enable), 1 priority threshold (bits [7:0]), 2 split point (bits [2:0]), 3 claim (read, ID in bits [9:0]), 4 retire (write, ID in bits [9:0]), 5 running priority (read, bits [7:0]), 6 top waiting (read, ID in bits [9:0]). Unmapped reads return 0.

Top module: `icc_cpu_if`

## Requirements
- R1: After reset the interface enable reads 0, the threshold reads 0xFF, the split point reads 0, the running priority reads 0xFF, `irqOut` is low and `eoiErr` is low.
- R2: A claim read returns the ID of the waiting line that is pending, not in service, and has the numerically lowest priority value, with ties going to the lowest ID. That line is in service from then on and is not returned again until it is retired.
- R3: A claim read returns 1023 and changes nothing when `distEnable` is low, when the interface enable is 0, or when no line qualifies.
- R4: A line qualifies only if its priority value is strictly below the threshold. A value equal to the threshold is refused.
- R5: With split value b, the group priority is the priority ANDed with (0xFF << (b+1)) in 8 bits. While a line is in service, a new line qualifies only if its group priority is strictly below the group priority of the most recently claimed line. The running-priority register reads that group priority, or 0xFF when nothing is in service.
- R6: Lines of equal group priority never preempt one another. Among waiting lines, the lower full priority value wins.
- R7: Writing the ID of the most recently claimed line to the retire register pops it. The running priority returns to the value it had before that claim, and the line may be claimed again.
- R8: A retire write whose ID is 1023, or does not match the most recently claimed line, leaves the in-service state unchanged and sets `eoiErr`, which stays set until reset.
- R9: Reading the top-waiting register returns the ID that a claim would choose by R2, ignoring the threshold, enables and preemption, or 1023 if no line is pending and out of service. The read claims nothing.
- R10: `irqOut` is high exactly when a claim read in that cycle would return an ID other than 1023.
- R11: When DEPTH lines are in service, every claim returns 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| distEnable | input | 1 | Distributor forwarding enable |
| pendVec | input | N | Forwarded pending lines, one per ID |
| prioFlat | input | 8*N | Priority of line i in bits [8i+7:8i] |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (claim side effect at address 3) |
| regAddr | input | 3 | Word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid in the cycle of the read |
| irqOut | output | 1 | Interrupt request to the core |
| eoiErr | output | 1 | Sticky bad-retire flag |

## Verification
The main stimulus is a sweep over every split point and a 16×16 grid of priority pairs. A first line is claimed, then a second line is raised on top of it. Each point separates three cases: a group strictly higher that preempts, an equal group that only differs in subpriority, and a value at the threshold that is refused. Directed patterns cover each source of 1023 (distributor off, interface off, threshold equal to the priority). They also cover equal priorities resolved by ID, a stack filled to capacity, and retire writes given out of order or with the spurious ID.

// File: rtl/icc_pkg.sv
package icc_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_THRESH = 3'd1,
    REG_SPLIT  = 3'd2,
    REG_CLAIM  = 3'd3,
    REG_RETIRE = 3'd4,
    REG_RUNPRI = 3'd5,
    REG_TOPPND = 3'd6
  } regSel_e;

  typedef struct packed {
    logic            push;
    logic            pop;
    logic [ID_W-1:0] pushId;
    logic [7:0]      pushGrp;
  } stackStrobe_t;
endpackage

// File: rtl/icc_datapath.sv
module icc_datapath
  import icc_pkg::*;
#(
  parameter int N     = 16,
  parameter int DEPTH = 8,
  localparam int DW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [N-1:0]    pendVec,
  input  logic [8*N-1:0]  prioFlat,
  input  stackStrobe_t    strb,
  output logic            candValid,
  output logic [ID_W-1:0] candId,
  output logic [7:0]      candPrio,
  output logic [ID_W-1:0] topId,
  output logic [7:0]      topGrp,
  output logic [DW-1:0]   depth
);
  logic [N-1:0]    activeVec;
  logic [ID_W-1:0] stkId  [DEPTH];
  logic [7:0]      stkGrp [DEPTH];
  logic [DW-1:0]   topIdx;

  // winner search: strict compare keeps the lowest ID on equal priority
  always_comb begin
    candValid = 1'b0;
    candId    = '0;
    candPrio  = 8'hFF;
    for (int i = 0; i < N; i++) begin
      if (pendVec[i] && !activeVec[i] &&
          (!candValid || prioFlat[8*i +: 8] < candPrio)) begin
        candValid = 1'b1;
        candId    = ID_W'(i);
        candPrio  = prioFlat[8*i +: 8];
      end
    end
  end

  assign topIdx = depth - DW'(1);
  assign topId  = (depth == '0) ? '0 : stkId[topIdx[IW-1:0]];
  assign topGrp = (depth == '0) ? 8'hFF : stkGrp[topIdx[IW-1:0]];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth <= '0;
    end else if (strb.pop) begin
      depth <= depth - DW'(1);
    end else if (strb.push) begin
      depth <= depth + DW'(1);
      stkId[depth[IW-1:0]]  <= strb.pushId;
      stkGrp[depth[IW-1:0]] <= strb.pushGrp;
    end
  end

  for (genvar g = 0; g < N; g++) begin : gActive
    always_ff @(posedge clk) begin
      if (!rstN)
        activeVec[g] <= 1'b0;
      else if (strb.pop && topId == ID_W'(g))
        activeVec[g] <= 1'b0;
      else if (strb.push && strb.pushId == ID_W'(g))
        activeVec[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/icc_control.sv
module icc_control
  import icc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            distEnable,
  input  logic            regWrEn,
  input  logic            regRdEn,
  input  logic [2:0]      regAddr,
  input  logic [31:0]     regWrData,
  output logic [31:0]     regRdData,
  input  logic            candValid,
  input  logic [ID_W-1:0] candId,
  input  logic [7:0]      candPrio,
  input  logic [ID_W-1:0] topId,
  input  logic [7:0]      topGrp,
  input  logic [DW-1:0]   depth,
  output stackStrobe_t    strb,
  output logic            ifEnable,
  output logic            irqOut,
  output logic            eoiErr
);
  logic [7:0] threshold;
  logic [2:0] splitPt;
  logic [7:0] grpMask;
  logic [7:0] candGrp;
  logic       preemptOk;
  logic       eligible;
  logic       claimRd;
  logic       retireWr;
  logic       retireHit;

  assign grpMask   = (8'hFF << splitPt) << 1;
  assign candGrp   = candPrio & grpMask;
  assign preemptOk = (depth == '0) || (candGrp < topGrp);
  assign eligible  = candValid && distEnable && ifEnable &&
                     (candPrio < threshold) && preemptOk &&
                     (depth < DW'(DEPTH));
  assign irqOut    = eligible;

  assign claimRd   = regRdEn && regAddr == REG_CLAIM;
  assign retireWr  = regWrEn && regAddr == REG_RETIRE;
  assign retireHit = (depth != '0) && (regWrData[ID_W-1:0] == topId) &&
                     (regWrData[ID_W-1:0] != SPURIOUS_ID);

  always_comb begin
    strb.push    = claimRd && eligible;
    strb.pop     = retireWr && retireHit;
    strb.pushId  = candId;
    strb.pushGrp = candGrp;
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_CTRL:   regRdData[0]      = ifEnable;
      REG_THRESH: regRdData[7:0]    = threshold;
      REG_SPLIT:  regRdData[2:0]    = splitPt;
      REG_CLAIM:  regRdData[ID_W-1:0] = eligible ? candId : SPURIOUS_ID;
      REG_RUNPRI: regRdData[7:0]    = topGrp;
      REG_TOPPND: regRdData[ID_W-1:0] = candValid ? candId : SPURIOUS_ID;
      default:    regRdData         = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ifEnable  <= 1'b0;
      threshold <= 8'hFF;
      splitPt   <= 3'd0;
      eoiErr    <= 1'b0;
    end else begin
      if (regWrEn && regAddr == REG_CTRL)   ifEnable  <= regWrData[0];
      if (regWrEn && regAddr == REG_THRESH) threshold <= regWrData[7:0];
      if (regWrEn && regAddr == REG_SPLIT)  splitPt   <= regWrData[2:0];
      if (retireWr && !retireHit)           eoiErr    <= 1'b1;
    end
  end
endmodule

// File: rtl/icc_cpu_if.sv
module icc_cpu_if
  import icc_pkg::*;
#(
  parameter int N     = 16,
  parameter int DEPTH = 8,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           distEnable,
  input  logic [N-1:0]   pendVec,
  input  logic [8*N-1:0] prioFlat,
  input  logic           regWrEn,
  input  logic           regRdEn,
  input  logic [2:0]     regAddr,
  input  logic [31:0]    regWrData,
  output logic [31:0]    regRdData,
  output logic           irqOut,
  output logic           eoiErr
);
  stackStrobe_t    strb;
  logic            candValid;
  logic [ID_W-1:0] candId;
  logic [7:0]      candPrio;
  logic [ID_W-1:0] topId;
  logic [7:0]      topGrp;
  logic [DW-1:0]   depthW;
  logic            ifEnableW;

  icc_datapath #(.N(N), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .prioFlat(prioFlat),
    .strb(strb), .candValid(candValid), .candId(candId),
    .candPrio(candPrio), .topId(topId), .topGrp(topGrp), .depth(depthW)
  );

  icc_control #(.DEPTH(DEPTH)) ctl_i (
    .clk(clk), .rstN(rstN), .distEnable(distEnable),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .candValid(candValid), .candId(candId), .candPrio(candPrio),
    .topId(topId), .topGrp(topGrp), .depth(depthW), .strb(strb),
    .ifEnable(ifEnableW), .irqOut(irqOut), .eoiErr(eoiErr)
  );
endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
  parameter int DEPTH = 8,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          distEnable,
  input logic          ifEnable,
  input logic          irqOut,
  input logic          regWrEn,
  input logic          regRdEn,
  input logic [2:0]    regAddr,
  input logic [31:0]   regWrData,
  input logic [31:0]   regRdData,
  input logic          eoiErr,
  input logic [DW-1:0] depth
);
  logic claimRd;
  assign claimRd = regRdEn && regAddr == 3'd3;

  assert_irq_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (distEnable && ifEnable));

  assert_spurious_dist_R3: assert property (@(posedge clk) disable iff (!rstN)
    (claimRd && !distEnable) |-> regRdData[9:0] == 10'd1023);

  assert_claim_push_R2: assert property (@(posedge clk) disable iff (!rstN)
    (claimRd && regRdData[9:0] != 10'd1023) |=> depth == $past(depth) + DW'(1));

  assert_irq_matches_claim_R10: assert property (@(posedge clk) disable iff (!rstN)
    claimRd |-> (irqOut == (regRdData[9:0] != 10'd1023)));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    eoiErr |=> eoiErr);

  assert_retire_spurious_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd4 && regWrData[9:0] == 10'd1023) |=> eoiErr);

  assert_depth_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    depth <= DW'(DEPTH));
endmodule

bind icc_cpu_if icc_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .distEnable(distEnable), .ifEnable(ifEnableW),
  .irqOut(irqOut), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .eoiErr(eoiErr),
  .depth(depthW)
);

// File: tb/icc_cpu_if_tb_top.sv
module icc_cpu_if_tb_top;
  localparam int N     = 16;
  localparam int DEPTH = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           distEnable = 1'b0;
  logic [N-1:0]   pendVec = '0;
  logic [8*N-1:0] prioFlat = '0;
  logic           regWrEn = 1'b0;
  logic           regRdEn = 1'b0;
  logic [2:0]     regAddr = '0;
  logic [31:0]    regWrData = '0;
  logic [31:0]    regRdData;
  logic           irqOut;
  logic           eoiErr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  icc_cpu_if #(.N(N), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .distEnable(distEnable), .pendVec(pendVec),
    .prioFlat(prioFlat), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .eoiErr(eoiErr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic busWr(input logic [2:0] a, input int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic busRd(input logic [2:0] a, output int d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = int'(regRdData);
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic setPrio(input int i, input int v);
    prioFlat[8*i +: 8] = v[7:0];
  endtask

  function automatic int grpOf(input int p, input int b);
    return p & ((8'hFF << b) << 1) & 8'hFF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int d, exp;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset values
    busRd(3'd0, d); check("R1 enable", d, 0);
    busRd(3'd1, d); check("R1 threshold", d, 255);
    busRd(3'd2, d); check("R1 split", d, 0);
    busRd(3'd5, d); check("R1 runpri", d, 255);
    check("R1 irq", irqOut, 0);
    check("R1 err", eoiErr, 0);

    // R3 spurious sources
    setPrio(2, 8'h40); pendVec = 16'h0004;
    busWr(3'd0, 1);
    busRd(3'd3, d); check("R3 dist off", d, 1023);
    distEnable = 1'b1;
    busWr(3'd0, 0);
    busRd(3'd3, d); check("R3 if off", d, 1023);
    busWr(3'd0, 1);
    // R4 threshold strict
    busWr(3'd1, 8'h40);
    #1 check("R4 irq at equal", irqOut, 0);
    busRd(3'd3, d); check("R4 equal threshold", d, 1023);
    // R9 top waiting ignores threshold and does not claim
    busRd(3'd6, d); check("R9 top waiting", d, 2);
    busWr(3'd1, 8'h41);
    #1 check("R10 irq high", irqOut, 1);
    busRd(3'd3, d); check("R4 below threshold", d, 2);
    busRd(3'd5, d); check("R5 runpri", d, 8'h40);
    // R8 bad retire: wrong ID, then spurious ID
    busWr(3'd4, 5);
    busRd(3'd5, d); check("R8 state kept", d, 8'h40);
    check("R8 err set", eoiErr, 1);
    busWr(3'd4, 1023);
    check("R8 err sticky", eoiErr, 1);
    pendVec = '0;
    busWr(3'd4, 2);
    busRd(3'd5, d); check("R7 retire pops", d, 255);
    check("R8 still sticky", eoiErr, 1);
    busRd(3'd6, d); check("R9 none pending", d, 1023);

    // R2 and R6: tie goes to lowest ID, equal group never preempts
    busWr(3'd1, 8'hFF);
    setPrio(3, 8'h40); setPrio(5, 8'h40); setPrio(9, 8'h41);
    pendVec = 16'h0228;
    busRd(3'd6, d); check("R2 tie lowest id", d, 3);
    busRd(3'd3, d); check("R2 claim tie", d, 3);
    busRd(3'd6, d); check("R2 claimed not returned", d, 5);
    busRd(3'd3, d); check("R6 no preempt same group", d, 1023);
    pendVec = 16'h0220;
    busWr(3'd4, 3);
    // with split 1, 0x41 and 0x40 share a group; full value orders them
    busWr(3'd2, 1);
    setPrio(5, 8'h42); setPrio(9, 8'h41);
    busRd(3'd3, d); check("R6 subpriority order", d, 9);
    busRd(3'd3, d); check("R6 same group blocked", d, 1023);
    pendVec = '0;
    busWr(3'd4, 9);
    busWr(3'd2, 0);

    // R11 stack capacity
    for (int i = 0; i <= DEPTH; i++) setPrio(i, 8'hF0 - 16 * i);
    for (int i = 0; i < DEPTH; i++) begin
      pendVec[i] = 1'b1;
      busRd(3'd3, d); check("R11 fill", d, i);
    end
    pendVec[DEPTH] = 1'b1;
    busRd(3'd3, d); check("R11 full spurious", d, 1023);
    pendVec = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      busRd(3'd5, d); check("R7 nested runpri", d, 8'hF0 - 16 * i);
      busWr(3'd4, i);
    end
    busRd(3'd5, d); check("R7 empty runpri", d, 255);

    // R5 sweep: split point x priority pairs, line 0 running, line 1 arriving
    for (int b = 0; b < 8; b++) begin
      busWr(3'd2, b);
      for (int p1 = 0; p1 < 256; p1 += 17) begin
        for (int p2 = 0; p2 < 256; p2 += 17) begin
          setPrio(0, p1); setPrio(1, p2);
          pendVec = 16'h0001;
          busRd(3'd3, d);
          check("R4 sweep first", d, (p1 < 255) ? 0 : 1023);
          if (d == 0) begin
            pendVec = 16'h0003;
            exp = (p2 < 255 && grpOf(p2, b) < grpOf(p1, b)) ? 1 : 1023;
            #1 check("R10 sweep irq", irqOut, (exp == 1) ? 1 : 0);
            busRd(3'd3, d); check("R5 sweep preempt", d, exp);
            pendVec = '0;
            if (d == 1) busWr(3'd4, 1);
            busRd(3'd5, d); check("R5 sweep runpri", d, grpOf(p1, b));
            busWr(3'd4, 0);
          end
          pendVec = '0;
        end
      end
    end
    finishRun();
  end
endmodule